// File: doc/BRIEF.md
# Mixed-Width Host Register Bridge

This bridge joins a 32-bit register request port to the register file of a storage host controller. That register file can sit behind a 16-bit, 32-bit or 64-bit data path, and a static mode input says which. For each request the bridge turns the logical register offset into a physical bus address and runs the matching bus cycles.

When the path is 16 bits wide, a small fixed set of registers is treated as 32 bits wide. For those, the bridge splits one access into two halfword cycles, or merges two halfword reads into one word. The set used for reads differs from the set used for writes. Every other access in 16-bit mode moves only the low halfword.

Both sides use a simple handshake. On the front, a request is held until a one-cycle ready pulse. On the bus side, a request is held until an acknowledge arrives.

Top module: `hostreg_bridge`

## Requirements
- R1: With `width_mode` = 2'b00 (or the reserved code 2'b11), each access runs one bus cycle at physical address equal to the logical offset. The cycle carries the full 32-bit write data, and a read returns all 32 bits of `bus_rdata`.
- R2: With `width_mode` = 2'b10 (64-bit path), each access runs one bus cycle at physical address equal to the logical offset shifted left by one, with full 32-bit data.
- R3: With `width_mode` = 2'b01 (16-bit path), the first bus cycle of every access uses the logical offset shifted right by one as its physical address.
- R4: In 16-bit mode, a read of a response register (offsets 0x030, 0x038, 0x040, 0x048) runs two back-to-back read cycles: first at address A, then at A+2. The result is {second[15:0], first[15:0]}.
- R5: In 16-bit mode, a write to a status register (0x070, 0x078), a status mask register (0x080, 0x088) or the argument register (0x010) runs two back-to-back write cycles. The first cycle is at A with {16'h0, wdata[15:0]}. The second is at A+2 with {16'h0, wdata[31:16]}.
- R6: In 16-bit mode, a read of any offset outside the response set, including the status and argument registers, runs one cycle and returns {16'h0, bus_rdata[15:0]}.
- R7: In 16-bit mode, a write to any offset outside the write set, including the response registers, runs one cycle carrying {16'h0, wdata[15:0]}, and bits 31:16 are dropped.
- R8: `bus_req` stays high with stable address, direction and data until `bus_ack`. `ready` pulses high for exactly one cycle, and only after the last bus cycle of the access has been acknowledged, never while `bus_req` is high.
- R9: `width_mode` is sampled only when an access is accepted. A change during an access affects only later accesses.
- R10: While reset is asserted, `ready` and `bus_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_mode | input | 2 | Register-file data path: 00 32-bit, 01 16-bit, 10 64-bit, 11 treated as 32-bit |
| req | input | 1 | Front access request, held until ready |
| we | input | 1 | 1 write, 0 read |
| ofs | input | OFS_W | Logical register offset |
| wdata | input | 32 | Front write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid with ready on reads |
| bus_req | output | 1 | Register-file bus cycle request |
| bus_we | output | 1 | Bus cycle direction |
| bus_addr | output | OFS_W+1 | Physical address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
The assertions rely on three things about the inputs. First, `bus_ack` is raised only while `bus_req` is high. Second, the front request and its arguments stay steady until `ready`, and `req` is dropped in the cycle `ready` is seen. Third, the check that the second halfword cycle steps the address by two assumes the bus side never acknowledges a non-split access and then sees a new access start in the very next cycle. The bridge's idle cycle after `ready` guarantees this. The bench's responder acknowledges only requested cycles after a fixed latency, and its front-end tasks hold every argument until `ready` is observed. Its mode change is applied mid-access only in the test written for R9.

// File: rtl/hostreg_bridge_pkg.sv
package hostreg_bridge_pkg;

    typedef enum logic [1:0] {
        WM_32  = 2'b00,
        WM_16  = 2'b01,
        WM_64  = 2'b10,
        WM_RSV = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_DONE
    } brst_e;

    localparam int DATA_W    = 32;
    localparam int HALF_W    = DATA_W / 2;
    localparam int N_RD_WIDE = 4;
    localparam int N_WR_WIDE = 5;

    // Registers read as two halfwords on a 16-bit path (response words).
    localparam logic [31:0] RD_WIDE_OFS [N_RD_WIDE] = '{
        32'h030, 32'h038, 32'h040, 32'h048
    };

    // Registers written as two halfwords on a 16-bit path
    // (argument, two status words, two status masks).
    localparam logic [31:0] WR_WIDE_OFS [N_WR_WIDE] = '{
        32'h010, 32'h070, 32'h078, 32'h080, 32'h088
    };

endpackage

// File: rtl/hostreg_addr_map.sv
module hostreg_addr_map
    import hostreg_bridge_pkg::*;
#(
    parameter int OFS_W = 11,
    localparam int PHY_W = OFS_W + 1
) (
    input  wmode_e             mode,
    input  logic [OFS_W-1:0]   ofs,
    output logic [PHY_W-1:0]   phys
);

    always_comb begin
        unique case (mode)
            WM_16:   phys = PHY_W'(ofs >> 1);
            WM_64:   phys = {ofs, 1'b0};
            default: phys = PHY_W'(ofs);
        endcase
    end

endmodule

// File: rtl/hostreg_wide_sel.sv
module hostreg_wide_sel
    import hostreg_bridge_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic             we,
    output logic             wide
);

    logic [N_RD_WIDE-1:0] hit_rd;
    logic [N_WR_WIDE-1:0] hit_wr;

    for (genvar i = 0; i < N_RD_WIDE; i++) begin : g_rd
        assign hit_rd[i] = (32'(ofs) == RD_WIDE_OFS[i]);
    end

    for (genvar j = 0; j < N_WR_WIDE; j++) begin : g_wr
        assign hit_wr[j] = (32'(ofs) == WR_WIDE_OFS[j]);
    end

    assign wide = we ? (|hit_wr) : (|hit_rd);

endmodule

// File: rtl/hostreg_bridge.sv
module hostreg_bridge
    import hostreg_bridge_pkg::*;
#(
    parameter int OFS_W = 11,
    localparam int PHY_W = OFS_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         width_mode,
    input  logic               req,
    input  logic               we,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [31:0]        wdata,
    output logic               ready,
    output logic [31:0]        rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [PHY_W-1:0]   bus_addr,
    output logic [31:0]        bus_wdata,
    input  logic [31:0]        bus_rdata,
    input  logic               bus_ack
);

    typedef struct packed {
        brst_e              st;
        wmode_e             mode;
        logic               we;
        logic               split;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic [PHY_W-1:0]   addr;
        logic [DATA_W-1:0]  bwdata;
    } brg_t;

    brg_t r_d, r_q;

    wmode_e             mode_in;
    logic [PHY_W-1:0]   phys;
    logic               wide;

    assign mode_in = wmode_e'(width_mode);

    hostreg_addr_map #(.OFS_W(OFS_W)) u_map (
        .mode (mode_in),
        .ofs  (ofs),
        .phys (phys)
    );

    hostreg_wide_sel #(.OFS_W(OFS_W)) u_sel (
        .ofs  (ofs),
        .we   (we),
        .wide (wide)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.st     = ST_LO;
                    r_d.mode   = mode_in;
                    r_d.we     = we;
                    r_d.wdata  = wdata;
                    r_d.split  = (mode_in == WM_16) && wide;
                    r_d.addr   = phys;
                    r_d.bwdata = (mode_in == WM_16) ? {{HALF_W{1'b0}}, wdata[HALF_W-1:0]}
                                                    : wdata;
                    r_d.rdata  = '0;
                end
            end
            ST_LO: begin
                if (bus_ack) begin
                    if (r_q.split) begin
                        r_d.st     = ST_HI;
                        r_d.rdata  = {{HALF_W{1'b0}}, bus_rdata[HALF_W-1:0]};
                        r_d.addr   = r_q.addr + PHY_W'(2);
                        r_d.bwdata = {{HALF_W{1'b0}}, r_q.wdata[DATA_W-1:HALF_W]};
                    end else begin
                        r_d.st    = ST_DONE;
                        r_d.rdata = (r_q.mode == WM_16) ? {{HALF_W{1'b0}}, bus_rdata[HALF_W-1:0]}
                                                        : bus_rdata;
                    end
                end
            end
            ST_HI: begin
                if (bus_ack) begin
                    r_d.st                    = ST_DONE;
                    r_d.rdata[DATA_W-1:HALF_W] = bus_rdata[HALF_W-1:0];
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mode: WM_32, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ready     = (r_q.st == ST_DONE);
    assign rdata     = r_q.rdata;
    assign bus_req   = (r_q.st == ST_LO) || (r_q.st == ST_HI);
    assign bus_we    = r_q.we;
    assign bus_addr  = r_q.addr;
    assign bus_wdata = r_q.bwdata;

endmodule

// File: rtl/hostreg_bridge_chk.sv
module hostreg_bridge_chk #(
    parameter int PHY_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             bus_req,
    input logic             bus_ack,
    input logic             bus_we,
    input logic [PHY_W-1:0] bus_addr,
    input logic [31:0]      bus_wdata
);

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (!ready && !bus_req));

    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));

    p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_ready_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !bus_req);

    p_ready_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(bus_req && bus_ack));

    p_hi_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req && bus_ack)) |-> (bus_addr == $past(bus_addr) + PHY_W'(2)));

    p_hi_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req && bus_ack)) |-> (bus_we == $past(bus_we)));

endmodule

bind hostreg_bridge hostreg_bridge_chk #(.PHY_W(PHY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/hostreg_bridge_tb.sv
module hostreg_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam int OFS_W = 11;
    localparam int PHY_W = OFS_W + 1;
    localparam int LAT = 2;
    localparam int NV = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] width_mode = 2'b00;
    logic req = 1'b0;
    logic we = 1'b0;
    logic [OFS_W-1:0] ofs = '0;
    logic [31:0] wdata = '0;
    logic ready;
    logic [31:0] rdata;
    logic bus_req, bus_we, bus_ack;
    logic [PHY_W-1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostreg_bridge #(.OFS_W(OFS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .width_mode(width_mode), .req(req), .we(we),
        .ofs(ofs), .wdata(wdata), .ready(ready), .rdata(rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // Bus responder model.
    function automatic logic [31:0] bus_val(input logic [PHY_W-1:0] a);
        return {~16'(a), 16'(a) ^ 16'h3C5A};
    endfunction

    int lat_cnt = 0;
    assign bus_ack   = bus_req && (lat_cnt == LAT);
    assign bus_rdata = bus_val(bus_addr);

    logic [PHY_W-1:0] log_a [0:127];
    logic             log_w [0:127];
    logic [31:0]      log_d [0:127];
    int nlog = 0;
    int stab_err = 0;
    logic             p_wait = 1'b0;
    logic [PHY_W-1:0] p_addr = '0;
    logic [31:0]      p_data = '0;

    always @(posedge clk) begin
        if (bus_req && bus_ack) begin
            if (nlog < 128) begin
                log_a[nlog] <= bus_addr;
                log_w[nlog] <= bus_we;
                log_d[nlog] <= bus_wdata;
            end
            nlog <= nlog + 1;
            lat_cnt <= 0;
        end else if (bus_req) begin
            lat_cnt <= lat_cnt + 1;
        end
        if (p_wait && bus_req && (bus_addr != p_addr || bus_wdata != p_data))
            stab_err <= stab_err + 1;
        p_wait <= bus_req && !bus_ack;
        p_addr <= bus_addr;
        p_data <= bus_wdata;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] m, input logic w, input logic [OFS_W-1:0] o,
                          input logic [31:0] d, output logic [31:0] rd, output int base);
        int guard;
        @(negedge clk);
        width_mode = m; we = w; ofs = o; wdata = d; req = 1'b1;
        base = nlog;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!ready && guard < 200);
        rd = rdata;
        req = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]       m;
        logic             w;
        logic [OFS_W-1:0] o;
        logic [31:0]      d;
        logic [3:0]       n;
        logic [PHY_W-1:0] a0;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b0, 11'h030, 32'h0,        4'd1, 12'h030},
        '{2'b00, 1'b1, 11'h070, 32'hDEADBEEF, 4'd1, 12'h070},
        '{2'b10, 1'b0, 11'h048, 32'h0,        4'd1, 12'h090},
        '{2'b10, 1'b1, 11'h010, 32'h12345678, 4'd1, 12'h020},
        '{2'b01, 1'b0, 11'h030, 32'h0,        4'd2, 12'h018},
        '{2'b01, 1'b0, 11'h048, 32'h0,        4'd2, 12'h024},
        '{2'b01, 1'b0, 11'h070, 32'h0,        4'd1, 12'h038},
        '{2'b01, 1'b1, 11'h070, 32'hAABBCCDD, 4'd2, 12'h038},
        '{2'b01, 1'b1, 11'h088, 32'h11223344, 4'd2, 12'h044},
        '{2'b01, 1'b1, 11'h010, 32'hCAFEF00D, 4'd2, 12'h008},
        '{2'b01, 1'b1, 11'h030, 32'h55667788, 4'd1, 12'h018},
        '{2'b01, 1'b0, 11'h010, 32'h0,        4'd1, 12'h008},
        '{2'b11, 1'b0, 11'h040, 32'h0,        4'd1, 12'h040},
        '{2'b01, 1'b1, 11'h080, 32'h0BADBEEF, 4'd2, 12'h040}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic [31:0] exp_rd;
        int base;
        string tag;

        repeat (3) @(negedge clk);
        chk(!ready && !bus_req, "R10", {30'b0, ready, bus_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic h;
            v = VEC[i];
            h = (v.m == 2'b01);
            if (h) tag = v.w ? ((v.n == 2) ? "R5" : "R7") : ((v.n == 2) ? "R4" : "R6");
            else   tag = (v.m == 2'b10) ? "R2" : "R1";
            access(v.m, v.w, v.o, v.d, rd, base);
            @(negedge clk);
            chk(nlog - base == int'(v.n), tag, 32'(nlog - base), 32'(v.n));
            chk(log_a[base] == v.a0, h ? "R3" : tag, 32'(log_a[base]), 32'(v.a0));
            chk(log_w[base] == v.w, tag, 32'(log_w[base]), 32'(v.w));
            if (v.w)
                chk(log_d[base] == (h ? {16'h0, v.d[15:0]} : v.d), tag, log_d[base],
                    h ? {16'h0, v.d[15:0]} : v.d);
            if (v.n == 2) begin
                chk(log_a[base+1] == v.a0 + 12'd2, tag, 32'(log_a[base+1]), 32'(v.a0 + 12'd2));
                chk(log_w[base+1] == v.w, tag, 32'(log_w[base+1]), 32'(v.w));
                if (v.w)
                    chk(log_d[base+1] == {16'h0, v.d[31:16]}, tag, log_d[base+1],
                        {16'h0, v.d[31:16]});
            end
            if (!v.w) begin
                if (!h)            exp_rd = bus_val(v.a0);
                else if (v.n == 2) exp_rd = {bus_val(v.a0 + 12'd2)[15:0], bus_val(v.a0)[15:0]};
                else               exp_rd = {16'h0, bus_val(v.a0)[15:0]};
                chk(rd == exp_rd, tag, rd, exp_rd);
            end
        end

        // R8: ready is one cycle wide and comes after both halfword cycles.
        @(negedge clk);
        width_mode = 2'b01; we = 1'b0; ofs = 11'h040; req = 1'b1;
        base = nlog;
        do @(negedge clk); while (!ready);
        req = 1'b0;
        chk(nlog - base == 2, "R8", 32'(nlog - base), 32'd2);
        @(negedge clk);
        chk(!ready, "R8", {31'b0, ready}, 32'h0);
        chk(stab_err == 0, "R8", 32'(stab_err), 32'h0);

        // R9: mode changed mid-access does not alter the access in flight.
        @(negedge clk);
        width_mode = 2'b01; we = 1'b0; ofs = 11'h030; req = 1'b1;
        base = nlog;
        @(negedge clk);
        width_mode = 2'b00;
        do @(negedge clk); while (!ready);
        rd = rdata;
        req = 1'b0;
        @(negedge clk);
        chk(nlog - base == 2, "R9", 32'(nlog - base), 32'd2);
        chk(log_a[base] == 12'h018, "R9", 32'(log_a[base]), 32'h018);
        exp_rd = {bus_val(12'h01A)[15:0], bus_val(12'h018)[15:0]};
        chk(rd == exp_rd, "R9", rd, exp_rd);
        access(2'b00, 1'b0, 11'h030, 32'h0, rd, base);
        @(negedge clk);
        chk(nlog - base == 1 && log_a[base] == 12'h030, "R9", 32'(log_a[base]), 32'h030);

        // R10: reset mid-access returns to quiet outputs.
        @(negedge clk);
        width_mode = 2'b01; we = 1'b1; ofs = 11'h070; wdata = 32'h1; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!ready && !bus_req, "R10", {30'b0, ready, bus_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule